// File: doc/BRIEF.md
# Two-Entry Host Command Queue with Role Check

This block sits between a host register bus and a bus-protocol execution engine. The host writes command bytes. Each accepted byte goes into a two-entry first-in first-out queue. The engine sees the oldest entry at the head outputs and retires it with a one-cycle done pulse. Every byte is decoded as it arrives:

- Bit 7 is a DMA request flag.
- Bits 6 to 4 name the bus role the command belongs to.

A byte whose role bits do not suit the current role of the controller is refused. A write that finds the queue full is also refused. Both cases raise a one-cycle illegal-command pulse.

Some commands carry no role bits. These miscellaneous commands are legal in every role. One of them, the chip-reset command, is never queued: it empties the queue on the edge that captures it. A command written twice, first plain and then with its DMA flag, therefore takes two queue entries, and the engine sees both in order.

Top module: `hcmd_queue`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `head_valid` and `illegal_pulse` are 0 and the queue is empty, whatever it held before.
- R2: A legal write to an empty queue shows that byte on `head_cmd` with `head_valid` = 1 right after the capturing clock edge.
- R3: Entries leave in write order. A second legal write while one entry is queued does not change the head. Writing the same byte without and with bit 7 set queues two separate entries.
- R4: `head_dma` equals bit 7 of the head byte while `head_valid` = 1, and is 0 when the queue is empty.
- R5: `head_class` reports the head byte's role group from bits 6..4:
  - 0 for miscellaneous (000)
  - 1 for disconnected (100)
  - 2 for target (010)
  - 3 for initiator (001)
  - It is 0 when the queue is empty.
- R6: `role` encodes 0 = disconnected, 1 = initiator, 2 = target. A byte whose single role bit (6 disconnected, 5 target, 4 initiator) does not match `role` is not queued. A byte with more than one of bits 6..4 set is not queued. In both cases `illegal_pulse` is 1 for the cycle after the write.
- R7: Bytes with bits 6..4 all 0 are accepted in every role.
- R8: A write that finds two entries queued, with no pop in the same cycle, is dropped. The head is unchanged and `illegal_pulse` is 1 in the following cycle.
- R9: A `pop` removes the head. The second entry is the head right after that edge. A `pop` on an empty queue has no effect.
- R10: A byte whose bits 6..0 equal 0x02 empties the queue on its capturing edge, with bit 7 either value. It is never queued, never flagged illegal, and overrides a `pop` in the same cycle.
- R11: `illegal_pulse` lasts exactly one cycle per refused write and is 0 unless the previous cycle carried a write.
- R12: A legal write in the same cycle as a `pop` on a full queue is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the command byte |
| wr_data | input | 8 | Command byte |
| role | input | 2 | Current bus role: 0 disconnected, 1 initiator, 2 target |
| pop | input | 1 | Engine done pulse, retires the head entry |
| head_cmd | output | 8 | Head command byte, 0 when empty |
| head_dma | output | 1 | DMA flag of the head command |
| head_class | output | 2 | Role group of the head command |
| head_valid | output | 1 | Queue holds at least one entry |
| illegal_pulse | output | 1 | One-cycle flag for a refused write |

## Verification
Every result of this block is registered, so each is due exactly one rising edge after the write, pop or reset that causes it:

- the new head and valid bit after an accepted write or a pop;
- the emptied queue after a chip-reset byte;
- the illegal flag after a refused write.

The bench drives each stimulus on the falling edge, waits for the next rising edge, and samples 1 ns later, so every check reads the state that edge produced. The following step then checks that the illegal flag has fallen again.

// File: rtl/hcq_pkg.sv
package hcq_pkg;

    localparam int CMD_W = 8;
    localparam logic [6:0] OP_CHIP_RESET = 7'h02;

    typedef enum logic [1:0] {
        ROLE_DISC = 2'd0,
        ROLE_INIT = 2'd1,
        ROLE_TARG = 2'd2,
        ROLE_NONE = 2'd3
    } role_e;

    typedef enum logic [1:0] {
        CLS_MISC = 2'd0,
        CLS_DISC = 2'd1,
        CLS_TARG = 2'd2,
        CLS_INIT = 2'd3
    } cls_e;

    typedef struct packed {
        logic [CMD_W-1:0] code;
        logic             dma;
        cls_e             cls;
    } entry_t;

    function automatic logic is_chip_reset(input logic [CMD_W-1:0] b);
        return b[6:0] == OP_CHIP_RESET;
    endfunction

endpackage

// File: rtl/hcq_decode.sv
module hcq_decode
    import hcq_pkg::*;
(
    input  logic [CMD_W-1:0] byte_in,
    input  logic [1:0]       role,
    output entry_t           ent,
    output logic             legal,
    output logic             chip_reset
);

    always_comb begin
        ent.code = byte_in;
        ent.dma  = byte_in[7];
        ent.cls  = CLS_MISC;
        legal    = 1'b0;
        unique case (byte_in[6:4])
            3'b000: begin
                ent.cls = CLS_MISC;
                legal   = 1'b1;
            end
            3'b100: begin
                ent.cls = CLS_DISC;
                legal   = (role == ROLE_DISC);
            end
            3'b010: begin
                ent.cls = CLS_TARG;
                legal   = (role == ROLE_TARG);
            end
            3'b001: begin
                ent.cls = CLS_INIT;
                legal   = (role == ROLE_INIT);
            end
            default: begin
                ent.cls = CLS_MISC;
                legal   = 1'b0;
            end
        endcase
        chip_reset = is_chip_reset(byte_in);
    end

endmodule

// File: rtl/hcq_store.sv
module hcq_store
    import hcq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        flush,
    input  logic                        push,
    input  entry_t                      push_ent,
    input  logic                        pop,
    output entry_t                      head,
    output logic [$clog2(DEPTH+1)-1:0]  fill,
    output logic                        can_push
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    entry_t             q     [DEPTH];
    entry_t             q_nxt [DEPTH];
    logic [CNT_W-1:0]   cnt_q;
    logic               pop_eff;
    logic [CNT_W-1:0]   cnt_after;

    assign pop_eff   = pop && (cnt_q != '0);
    assign cnt_after = cnt_q - CNT_W'(pop_eff);
    assign can_push  = cnt_after < CNT_W'(DEPTH);

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        entry_t shifted;
        if (gi == DEPTH - 1) begin : g_last
            assign shifted = pop_eff ? entry_t'('0) : q[gi];
        end else begin : g_mid
            assign shifted = pop_eff ? q[gi+1] : q[gi];
        end

        always_comb begin
            if (push && cnt_after == CNT_W'(gi))
                q_nxt[gi] = push_ent;
            else
                q_nxt[gi] = shifted;
        end

        always_ff @(posedge clk) begin
            if (rst || flush)
                q[gi] <= '0;
            else
                q[gi] <= q_nxt[gi];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush)
            cnt_q <= '0;
        else
            cnt_q <= cnt_after + CNT_W'(push);
    end

    assign head = q[0];
    assign fill = cnt_q;

endmodule

// File: rtl/hcmd_queue.sv
module hcmd_queue
    import hcq_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [1:0]        role,
    input  logic              pop,
    output logic [7:0]        head_cmd,
    output logic              head_dma,
    output logic [1:0]        head_class,
    output logic              head_valid,
    output logic              illegal_pulse
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    entry_t           dec_ent;
    entry_t           head;
    logic             dec_legal;
    logic             dec_reset;
    logic             can_push;
    logic [CNT_W-1:0] fill;
    logic             do_flush;
    logic             do_push;
    logic             refuse;
    logic             illegal_q;

    hcq_decode u_dec (
        .byte_in    (wr_data),
        .role       (role),
        .ent        (dec_ent),
        .legal      (dec_legal),
        .chip_reset (dec_reset)
    );

    assign do_flush = wr_en && dec_reset;
    assign do_push  = wr_en && !dec_reset && dec_legal && can_push;
    assign refuse   = wr_en && !dec_reset && (!dec_legal || !can_push);

    hcq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (do_flush),
        .push     (do_push),
        .push_ent (dec_ent),
        .pop      (pop),
        .head     (head),
        .fill     (fill),
        .can_push (can_push)
    );

    always_ff @(posedge clk) begin
        if (rst)
            illegal_q <= 1'b0;
        else
            illegal_q <= refuse;
    end

    assign head_cmd      = head.code;
    assign head_dma      = head.dma;
    assign head_class    = head.cls;
    assign head_valid    = fill != '0;
    assign illegal_pulse = illegal_q;

endmodule

// File: rtl/hcq_chk.sv
module hcq_chk #(
    parameter int DEPTH = 2
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en,
    input logic [7:0]                  wr_data,
    input logic                        pop,
    input logic [7:0]                  head_cmd,
    input logic                        head_dma,
    input logic                        head_valid,
    input logic                        illegal_pulse,
    input logic [$clog2(DEPTH+1)-1:0]  fill
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!head_valid && !illegal_pulse));

    // R4
    dma_bit_chk: assert property (@(posedge clk) disable iff (rst)
        head_valid |-> (head_dma == head_cmd[7]));

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fill == DEPTH && !pop && wr_data[6:0] != 7'h02)
        |=> (illegal_pulse && $stable(head_cmd)));

    // R9
    pop_last_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && fill == 1 && !wr_en) |=> !head_valid);

    // R10
    chip_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[6:0] == 7'h02) |=> (!head_valid && !illegal_pulse));

    // R11
    pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_pulse |-> $past(wr_en));

endmodule

bind hcmd_queue hcq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .pop           (pop),
    .head_cmd      (head_cmd),
    .head_dma      (head_dma),
    .head_valid    (head_valid),
    .illegal_pulse (illegal_pulse),
    .fill          (fill)
);

// File: tb/test_hcmd_queue.sv
`timescale 1ns/1ps
module test_hcmd_queue;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] role = 2'd0;
    logic       pop = 1'b0;
    logic [7:0] head_cmd;
    logic       head_dma;
    logic [1:0] head_class;
    logic       head_valid;
    logic       illegal_pulse;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    hcmd_queue i_hcmd_queue (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .role          (role),
        .pop           (pop),
        .head_cmd      (head_cmd),
        .head_dma      (head_dma),
        .head_class    (head_class),
        .head_valid    (head_valid),
        .illegal_pulse (illegal_pulse)
    );

    // Vector layout:
    //   [28:25] req  [24] wr  [23:16] data  [15:14] role  [13] pop
    //   expected: [12] valid  [11:4] cmd  [3] dma  [2:1] class  [0] illegal
    localparam int NV = 17;
    localparam logic [28:0] VECS [NV] = '{
        {4'd2,  1'b1, 8'h10, 2'd1, 1'b0, 1'b1, 8'h10, 1'b0, 2'd3, 1'b0}, // R2 R5
        {4'd3,  1'b1, 8'h90, 2'd1, 1'b0, 1'b1, 8'h10, 1'b0, 2'd3, 1'b0}, // R3 same cmd + DMA
        {4'd8,  1'b1, 8'h11, 2'd1, 1'b0, 1'b1, 8'h10, 1'b0, 2'd3, 1'b1}, // R8 full
        {4'd11, 1'b0, 8'h00, 2'd1, 1'b0, 1'b1, 8'h10, 1'b0, 2'd3, 1'b0}, // R11 pulse ends
        {4'd4,  1'b0, 8'h00, 2'd1, 1'b1, 1'b1, 8'h90, 1'b1, 2'd3, 1'b0}, // R4 R9 R3 advance
        {4'd9,  1'b0, 8'h00, 2'd1, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0}, // R9 empties
        {4'd9,  1'b0, 8'h00, 2'd1, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0}, // R9 pop empty
        {4'd6,  1'b1, 8'h22, 2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1}, // R6 target in init
        {4'd6,  1'b1, 8'h41, 2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b1}, // R6 disc in init
        {4'd5,  1'b1, 8'h22, 2'd2, 1'b0, 1'b1, 8'h22, 1'b0, 2'd2, 1'b0}, // R5 target ok
        {4'd7,  1'b1, 8'h03, 2'd2, 1'b0, 1'b1, 8'h22, 1'b0, 2'd2, 1'b0}, // R7 misc
        {4'd6,  1'b1, 8'h30, 2'd2, 1'b0, 1'b1, 8'h22, 1'b0, 2'd2, 1'b1}, // R6 two role bits
        {4'd12, 1'b1, 8'hC1, 2'd0, 1'b1, 1'b1, 8'h03, 1'b0, 2'd0, 1'b0}, // R12 pop+write full
        {4'd5,  1'b0, 8'h00, 2'd0, 1'b1, 1'b1, 8'hC1, 1'b1, 2'd1, 1'b0}, // R5 disc class
        {4'd10, 1'b1, 8'h82, 2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0}, // R10 reset w/ DMA
        {4'd7,  1'b1, 8'h01, 2'd0, 1'b0, 1'b1, 8'h01, 1'b0, 2'd0, 1'b0}, // R7 misc in disc
        {4'd10, 1'b1, 8'h02, 2'd0, 1'b1, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0}  // R10 beats pop
    };

    task automatic step(input logic w, input logic [7:0] d,
                        input logic [1:0] r, input logic p);
        @(negedge clk);
        wr_en   = w;
        wr_data = d;
        role    = r;
        pop     = p;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input int req, input logic [12:0] exp);
        logic [12:0] got;
        got = {head_valid, head_cmd, head_dma, head_class, illegal_pulse};
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d got=%h expected=%h", req, got, exp);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        check(1, 13'h0); // R1 reset state
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][24], VECS[i][23:16], VECS[i][15:14], VECS[i][13]);
            check(int'(VECS[i][28:25]), VECS[i][12:0]);
        end

        // R1: reset empties a full queue
        step(1'b1, 8'h12, 2'd1, 1'b0);
        step(1'b1, 8'h1a, 2'd1, 1'b0);
        check(3, {1'b1, 8'h12, 1'b0, 2'd3, 1'b0}); // R3 order kept
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        @(posedge clk);
        #1;
        check(1, 13'h0);
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 8'h00, 2'd1, 1'b1);
        check(1, 13'h0); // R1 nothing left after reset

        // R11: back-to-back refused writes give back-to-back pulses, then drop
        step(1'b1, 8'h20, 2'd1, 1'b0);
        check(11, {1'b0, 8'h00, 1'b0, 2'd0, 1'b1});
        step(1'b1, 8'h70, 2'd1, 1'b0);
        check(11, {1'b0, 8'h00, 1'b0, 2'd0, 1'b1});
        step(1'b0, 8'h00, 2'd1, 1'b0);
        check(11, 13'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule